// File: doc/BRIEF.md
# Geometry Primitive Emitter

The emitter sits after a geometry shading unit and turns vertex-emit commands into a stream of finished triangles. A configuration write loads a per-register selection mask, which stays in force until the next write. Each emit command carries a snapshot of the shader's sixteen four-component output registers, a target vertex index and two flags. The selected registers are packed densely, lowest register number first, into attribute slots. The packed vertex is then stored in one of three triangle-buffer entries.

When an emit carries the primitive flag, the emitter first stores the new vertex. It then sends the whole buffer downstream as three beats on a valid/ready stream, entry 0 first. If the winding flag is also set, a one-cycle winding strobe comes before the first beat. While a triangle is in flight, the command side is held off. A command naming a vertex index outside the buffer is dropped and reported on an error pulse.

Top module: `gpe_emitter`

## Requirements
- R1: During and after reset, until the first command, `emit_ready_o` is 1 and `vtx_valid_o`, `wind_strobe_o` and `err_idx_o` are 0. The selection mask resets to all zeros.
- R2: A stored vertex holds the registers whose mask bit is 1, in ascending register order, in slots 0, 1, 2 and so on. Register j of `emit_regs_i` occupies bits [j*96 +: 96]. Slot k of `vtx_data_o` occupies bits [k*96 +: 96]. Component c sits at offset c*24 inside a register or slot.
- R3: Slots numbered at or above the count of set mask bits read as zero.
- R4: A pulse on `cfg_mask_we_i` loads `cfg_mask_i`, and the new mask applies to every later emit. An emit accepted in the same cycle as a mask load uses the mask that was in force before that load.
- R5: An accepted emit with index 0, 1 or 2 replaces only that buffer entry. The other entries keep their contents.
- R6: For an accepted emit with the primitive flag, the stream sends entries 0, 1 and 2 in that order. `vtx_seq_o` gives the entry number of each beat, and the beats include the vertex stored by that same emit. Without the winding flag, the first beat is valid in the cycle after acceptance.
- R7: With both the primitive and winding flags, `wind_strobe_o` is 1 for exactly the cycle after acceptance, and the first beat follows in the next cycle. Without the winding flag, the strobe stays 0.
- R8: While `vtx_valid_o` is 1 and `vtx_ready_i` is 0, the valid signal, `vtx_seq_o` and `vtx_data_o` hold their values.
- R9: `emit_ready_o` is 0 from the cycle after a primitive emit is accepted until the last beat has been accepted. Emits presented during that time are not taken and change no buffer entry.
- R10: An accepted emit with index 3 is discarded: no entry is written and no stream starts, even with the primitive flag set. `err_idx_o` is 1 for one cycle, the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_mask_we_i | input | 1 | Load strobe for the selection mask |
| cfg_mask_i | input | 16 | Register selection mask, bit j selects register j |
| emit_valid_i | input | 1 | Emit command present |
| emit_ready_o | output | 1 | Emit command can be accepted |
| emit_idx_i | input | 2 | Target buffer entry |
| emit_prim_i | input | 1 | Send the buffered triangle after storing this vertex |
| emit_wind_i | input | 1 | Raise the winding strobe before the triangle |
| emit_regs_i | input | 1536 | Snapshot of 16 output registers, 4 x 24 bits each |
| err_idx_o | output | 1 | One-cycle pulse for a discarded out-of-range emit |
| wind_strobe_o | output | 1 | One-cycle winding indication ahead of a triangle |
| vtx_valid_o | output | 1 | Vertex beat valid |
| vtx_ready_i | input | 1 | Downstream accepts the beat |
| vtx_seq_o | output | 2 | Buffer entry number of the current beat |
| vtx_data_o | output | 1536 | Packed vertex, 16 slots of 4 x 24 bits |

## Verification
The packing is exercised with four masks. A full mask must reproduce the register file unchanged. A sparse mask with one bit in each nibble separates rank-based placement from direct placement and checks that the upper slots are cleared. An all-zero mask must give a fully zero vertex. A mask reload in the same cycle as an emit distinguishes the registered mask from the incoming one. Triangle streaming is run with and without the winding flag and with and without downstream stalls, which exposes ordering, hold and strobe-placement faults. Emits offered while a triangle is in flight, and an emit at index 3, are then followed by a later triangle, which shows whether any buffer entry was disturbed.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

  typedef enum logic [1:0] {
    GPE_IDLE = 2'd0,
    GPE_WIND = 2'd1,
    GPE_SEND = 2'd2
  } gpe_state_e;

  localparam int GPE_COMPONENTS = 4;

endpackage

// File: rtl/gpe_compactor.sv
module gpe_compactor #(
  parameter  int NUM_REGS = 16,
  parameter  int REG_W    = 96,
  localparam int VEC_W    = NUM_REGS * REG_W,
  localparam int RANK_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [NUM_REGS-1:0] mask_i,
  input  logic [VEC_W-1:0]    regs_i,
  output logic [VEC_W-1:0]    slots_o
);

  logic [REG_W-1:0]  reg_arr  [NUM_REGS];
  logic [REG_W-1:0]  slot_arr [NUM_REGS];
  logic [RANK_W-1:0] rank     [NUM_REGS];
  logic [RANK_W-1:0] run_cnt;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign reg_arr[g]                 = regs_i[g*REG_W +: REG_W];
    assign slots_o[g*REG_W +: REG_W]  = slot_arr[g];
  end

  // rank of register j = number of selected registers below it
  always_comb begin
    run_cnt = '0;
    for (int j = 0; j < NUM_REGS; j++) begin
      rank[j] = run_cnt;
      run_cnt = run_cnt + RANK_W'(mask_i[j]);
    end
  end

  // scatter every selected register to the slot given by its rank
  always_comb begin
    for (int k = 0; k < NUM_REGS; k++) begin
      slot_arr[k] = '0;
    end
    for (int j = 0; j < NUM_REGS; j++) begin
      if (mask_i[j]) begin
        slot_arr[rank[j]] = reg_arr[j];
      end
    end
  end

endmodule

// File: rtl/gpe_vertex_buf.sv
module gpe_vertex_buf #(
  parameter  int NUM_VTX = 3,
  parameter  int VTX_W   = 1536,
  localparam int IDX_W   = (NUM_VTX > 1) ? $clog2(NUM_VTX) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VTX_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [VTX_W-1:0] rd_data_o
);

  logic [VTX_W-1:0] entry_q [NUM_VTX];
  logic [NUM_VTX-1:0] entry_en;

  for (genvar i = 0; i < NUM_VTX; i++) begin : g_entry
    assign entry_en[i] = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_q[i] <= '0;
      end else if (entry_en[i]) begin
        entry_q[i] <= wr_data_i;
      end
    end

    AST_ENTRY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && (wr_idx_i == IDX_W'(i))) |=> $stable(entry_q[i])); // R5
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_VTX; i++) begin
      if (rd_idx_i == IDX_W'(i)) begin
        rd_data_o = entry_q[i];
      end
    end
  end

endmodule

// File: rtl/gpe_stream_ctrl.sv
module gpe_stream_ctrl
  import gpe_pkg::*;
#(
  parameter  int NUM_VTX = 3,
  localparam int IDX_W   = (NUM_VTX > 1) ? $clog2(NUM_VTX) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             emit_valid_i,
  output logic             emit_ready_o,
  input  logic [IDX_W-1:0] emit_idx_i,
  input  logic             emit_prim_i,
  input  logic             emit_wind_i,
  output logic             buf_we_o,
  output logic             err_idx_o,
  output logic             wind_strobe_o,
  output logic             vtx_valid_o,
  input  logic             vtx_ready_i,
  output logic [IDX_W-1:0] vtx_seq_o
);

  localparam logic [IDX_W-1:0] LAST_SEQ = IDX_W'(NUM_VTX - 1);

  gpe_state_e       state_q, state_d;
  logic [IDX_W-1:0] seq_q, seq_d;
  logic             seq_en;
  logic             err_q, err_d;
  logic             emit_fire;
  logic             idx_ok;

  assign emit_ready_o  = (state_q == GPE_IDLE);
  assign emit_fire     = emit_valid_i && emit_ready_o;
  assign idx_ok        = ({1'b0, emit_idx_i} < (IDX_W+1)'(NUM_VTX));
  assign buf_we_o      = emit_fire && idx_ok;
  assign vtx_valid_o   = (state_q == GPE_SEND);
  assign wind_strobe_o = (state_q == GPE_WIND);
  assign vtx_seq_o     = seq_q;
  assign err_idx_o     = err_q;

  always_comb begin
    state_d = state_q;
    seq_d   = seq_q;
    seq_en  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      GPE_IDLE: begin
        if (emit_fire) begin
          if (!idx_ok) begin
            err_d = 1'b1;
          end else if (emit_prim_i) begin
            seq_d   = '0;
            seq_en  = 1'b1;
            state_d = emit_wind_i ? GPE_WIND : GPE_SEND;
          end
        end
      end
      GPE_WIND: begin
        state_d = GPE_SEND;
      end
      GPE_SEND: begin
        if (vtx_ready_i) begin
          if (seq_q == LAST_SEQ) begin
            state_d = GPE_IDLE;
          end else begin
            seq_d  = seq_q + 1'b1;
            seq_en = 1'b1;
          end
        end
      end
      default: begin
        state_d = GPE_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GPE_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q <= '0;
    end else if (seq_en) begin
      seq_q <= seq_d;
    end
  end

  AST_PRIM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_fire && idx_ok && emit_prim_i) |=> !emit_ready_o); // R9
  AST_LAST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vtx_valid_o && vtx_ready_i && (vtx_seq_o == LAST_SEQ)) |=> emit_ready_o); // R9
  AST_HOLD_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vtx_valid_o && !vtx_ready_i) |=> (vtx_valid_o && $stable(vtx_seq_o))); // R8
  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vtx_valid_o && vtx_ready_i && (vtx_seq_o != LAST_SEQ))
      |=> (vtx_valid_o && (vtx_seq_o == IDX_W'($past(vtx_seq_o) + 1'b1)))); // R6
  AST_WIND_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wind_strobe_o |=> (vtx_valid_o && (vtx_seq_o == '0))); // R7
  AST_BAD_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_fire && !idx_ok) |=> (err_idx_o && emit_ready_o)); // R10

endmodule

// File: rtl/gpe_emitter.sv
module gpe_emitter #(
  parameter  int NUM_REGS = 16,
  parameter  int COMP_W   = 24,
  parameter  int NUM_VTX  = 3,
  localparam int REG_W    = gpe_pkg::GPE_COMPONENTS * COMP_W,
  localparam int VTX_W    = NUM_REGS * REG_W,
  localparam int IDX_W    = (NUM_VTX > 1) ? $clog2(NUM_VTX) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_mask_we_i,
  input  logic [NUM_REGS-1:0] cfg_mask_i,
  input  logic                emit_valid_i,
  output logic                emit_ready_o,
  input  logic [IDX_W-1:0]    emit_idx_i,
  input  logic                emit_prim_i,
  input  logic                emit_wind_i,
  input  logic [VTX_W-1:0]    emit_regs_i,
  output logic                err_idx_o,
  output logic                wind_strobe_o,
  output logic                vtx_valid_o,
  input  logic                vtx_ready_i,
  output logic [IDX_W-1:0]    vtx_seq_o,
  output logic [VTX_W-1:0]    vtx_data_o
);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // selection mask register with explicit load enable
  logic [NUM_REGS-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      mask_q <= '0;
    end else if (cfg_mask_we_i) begin
      mask_q <= cfg_mask_i;
    end
  end

  logic [VTX_W-1:0] packed_vtx;
  logic             buf_we;

  gpe_compactor #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W)
  ) compactor_i (
    .mask_i  (mask_q),
    .regs_i  (emit_regs_i),
    .slots_o (packed_vtx)
  );

  gpe_stream_ctrl #(
    .NUM_VTX (NUM_VTX)
  ) ctrl_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_q),
    .emit_valid_i  (emit_valid_i),
    .emit_ready_o  (emit_ready_o),
    .emit_idx_i    (emit_idx_i),
    .emit_prim_i   (emit_prim_i),
    .emit_wind_i   (emit_wind_i),
    .buf_we_o      (buf_we),
    .err_idx_o     (err_idx_o),
    .wind_strobe_o (wind_strobe_o),
    .vtx_valid_o   (vtx_valid_o),
    .vtx_ready_i   (vtx_ready_i),
    .vtx_seq_o     (vtx_seq_o)
  );

  gpe_vertex_buf #(
    .NUM_VTX (NUM_VTX),
    .VTX_W   (VTX_W)
  ) vbuf_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .wr_en_i   (buf_we),
    .wr_idx_i  (emit_idx_i),
    .wr_data_i (packed_vtx),
    .rd_idx_i  (vtx_seq_o),
    .rd_data_o (vtx_data_o)
  );

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (vtx_valid_o && !vtx_ready_i) |=> $stable(vtx_data_o)); // R8
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    wind_strobe_o |-> (!vtx_valid_o && !emit_ready_o)); // R7
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    err_idx_o |-> (!vtx_valid_o && !wind_strobe_o)); // R10

endmodule

// File: tb/gpe_emitter_tb_top.sv
module gpe_emitter_tb_top;

  localparam int NR = 16;
  localparam int CW = 24;
  localparam int RW = 4 * CW;
  localparam int VW = NR * RW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [NR-1:0] cfg_mask;
  logic          e_valid;
  logic          e_ready;
  logic [1:0]    e_idx;
  logic          e_prim;
  logic          e_wind;
  logic [VW-1:0] e_regs;
  logic          err_idx;
  logic          wind_strobe;
  logic          v_valid;
  logic          v_ready;
  logic [1:0]    v_seq;
  logic [VW-1:0] v_data;

  int tests = 0;
  int fails = 0;

  logic [NR-1:0] mask_m;
  logic [VW-1:0] exp_buf [3];

  always #10 clk = ~clk;

  gpe_emitter dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cfg_mask_we_i (cfg_we),
    .cfg_mask_i    (cfg_mask),
    .emit_valid_i  (e_valid),
    .emit_ready_o  (e_ready),
    .emit_idx_i    (e_idx),
    .emit_prim_i   (e_prim),
    .emit_wind_i   (e_wind),
    .emit_regs_i   (e_regs),
    .err_idx_o     (err_idx),
    .wind_strobe_o (wind_strobe),
    .vtx_valid_o   (v_valid),
    .vtx_ready_i   (v_ready),
    .vtx_seq_o     (v_seq),
    .vtx_data_o    (v_data)
  );

  function automatic logic [VW-1:0] mk_regs(input logic [7:0] seed);
    logic [VW-1:0] r;
    for (int j = 0; j < NR; j++)
      for (int c = 0; c < 4; c++)
        r[(j*4+c)*CW +: CW] = {seed, 8'(j), 8'(c)};
    return r;
  endfunction

  function automatic logic [VW-1:0] pack_ref(input logic [VW-1:0] regs, input logic [NR-1:0] m);
    logic [VW-1:0] o;
    int k;
    o = '0;
    k = 0;
    for (int j = 0; j < NR; j++) begin
      if (m[j]) begin
        o[k*RW +: RW] = regs[j*RW +: RW];
        k++;
      end
    end
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic load_mask(input logic [NR-1:0] m);
    cfg_we = 1'b1; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
    mask_m = m;
  endtask

  // drives one emit for one cycle; returns at the negedge after acceptance
  task automatic emit_cmd(input logic [1:0] idx, input bit prim, input bit wind,
                          input logic [7:0] seed, input bit ld, input logic [NR-1:0] ldm);
    e_valid = 1'b1; e_idx = idx; e_prim = prim; e_wind = wind; e_regs = mk_regs(seed);
    cfg_we = ld; cfg_mask = ldm;
    @(negedge clk);
    e_valid = 1'b0; e_prim = 1'b0; e_wind = 1'b0; cfg_we = 1'b0;
    if (idx < 2'd3) exp_buf[idx] = pack_ref(mk_regs(seed), mask_m);
    if (ld) mask_m = ldm;
  endtask

  task automatic recv_prim(input bit wind, input bit stall, input string tag);
    logic [VW-1:0] held;
    if (wind) begin
      chk(wind_strobe == 1'b1, {tag, " R7 strobe"}, VW'(wind_strobe), VW'(1));
      chk(v_valid == 1'b0, {tag, " R7 no beat with strobe"}, VW'(v_valid), VW'(0));
      @(negedge clk);
      chk(wind_strobe == 1'b0, {tag, " R7 strobe one cycle"}, VW'(wind_strobe), VW'(0));
    end else begin
      chk(wind_strobe == 1'b0, {tag, " R7 no strobe"}, VW'(wind_strobe), VW'(0));
    end
    for (int b = 0; b < 3; b++) begin
      if (stall) begin
        held = v_data;
        chk(e_ready == 1'b0, {tag, " R9 busy"}, VW'(e_ready), VW'(0));
        @(negedge clk);
        chk(v_valid && v_data == held && v_seq == 2'(b), {tag, " R8 hold"}, v_data, held);
      end
      chk(v_valid == 1'b1, {tag, " R6 valid"}, VW'(v_valid), VW'(1));
      chk(v_seq == 2'(b), {tag, " R6 order"}, VW'(v_seq), VW'(b));
      chk(v_data == exp_buf[b], {tag, " R2 data"}, v_data, exp_buf[b]);
      v_ready = 1'b1;
      @(negedge clk);
      v_ready = 1'b0;
    end
    chk(e_ready == 1'b1 && v_valid == 1'b0, {tag, " R9 release"}, VW'({e_ready, v_valid}), VW'(2));
  endtask

  task automatic t_reset();
    chk(e_ready == 1'b1, "R1 emit_ready", VW'(e_ready), VW'(1));
    chk(v_valid == 1'b0 && wind_strobe == 1'b0 && err_idx == 1'b0, "R1 outputs idle",
        VW'({v_valid, wind_strobe, err_idx}), VW'(0));
    // reset mask of zero: a triangle from fresh emits must be all zero
    emit_cmd(2'd0, 0, 0, 8'h11, 0, '0);
    emit_cmd(2'd1, 0, 0, 8'h12, 0, '0);
    emit_cmd(2'd2, 1, 0, 8'h13, 0, '0);
    chk(v_data == '0, "R1 reset mask zero", v_data, '0);
    recv_prim(0, 0, "reset");
  endtask

  task automatic t_full_mask();
    load_mask(16'hFFFF);
    emit_cmd(2'd0, 0, 0, 8'h21, 0, '0);
    emit_cmd(2'd1, 0, 0, 8'h22, 0, '0);
    emit_cmd(2'd2, 1, 0, 8'h23, 0, '0);
    chk(v_data == mk_regs(8'h21), "R2 full mask identity", v_data, mk_regs(8'h21));
    recv_prim(0, 0, "full");
  endtask

  task automatic t_sparse_wind_stall();
    logic [VW-1:0] e;
    load_mask(16'h8421);
    emit_cmd(2'd1, 1, 1, 8'h31, 0, '0);
    e = '0;
    e[0*RW +: RW] = mk_regs(8'h31)[0*RW +: RW];
    e[1*RW +: RW] = mk_regs(8'h31)[5*RW +: RW];
    e[2*RW +: RW] = mk_regs(8'h31)[10*RW +: RW];
    e[3*RW +: RW] = mk_regs(8'h31)[15*RW +: RW];
    chk(exp_buf[1] == e, "R3 bench reference sparse", exp_buf[1], e);
    recv_prim(1, 1, "sparse");
    chk(exp_buf[0] == mk_regs(8'h21), "R5 entry0 kept", exp_buf[0], mk_regs(8'h21));
  endtask

  task automatic t_zero_mask();
    load_mask(16'h0000);
    emit_cmd(2'd0, 1, 0, 8'h41, 0, '0);
    chk(v_seq == 2'd0 && v_data == '0, "R3 zero mask vertex", v_data, '0);
    recv_prim(0, 0, "zero");
  endtask

  task automatic t_mask_same_cycle();
    load_mask(16'h00F0);
    emit_cmd(2'd2, 0, 0, 8'h51, 1, 16'h0003);
    emit_cmd(2'd0, 1, 0, 8'h52, 0, '0);
    chk(exp_buf[2] == pack_ref(mk_regs(8'h51), 16'h00F0), "R4 old mask ref",
        exp_buf[2], pack_ref(mk_regs(8'h51), 16'h00F0));
    recv_prim(0, 0, "mask_edge");
  endtask

  task automatic t_bad_index();
    emit_cmd(2'd3, 1, 1, 8'h61, 0, '0);
    chk(err_idx == 1'b1, "R10 error pulse", VW'(err_idx), VW'(1));
    chk(v_valid == 1'b0 && wind_strobe == 1'b0, "R10 no stream", VW'({v_valid, wind_strobe}), VW'(0));
    @(negedge clk);
    chk(err_idx == 1'b0, "R10 pulse one cycle", VW'(err_idx), VW'(0));
    chk(v_valid == 1'b0 && e_ready == 1'b1, "R10 idle after discard", VW'({v_valid, e_ready}), VW'(1));
    emit_cmd(2'd1, 1, 0, 8'h62, 0, '0);
    recv_prim(0, 0, "bad_idx R5");
  endtask

  task automatic t_busy_ignored();
    load_mask(16'hFFFF);
    emit_cmd(2'd2, 1, 0, 8'h71, 0, '0);
    e_valid = 1'b1; e_idx = 2'd0; e_prim = 1'b1; e_regs = mk_regs(8'hEE);
    chk(e_ready == 1'b0, "R9 not ready in stream", VW'(e_ready), VW'(0));
    @(negedge clk);
    e_valid = 1'b0; e_prim = 1'b0;
    recv_prim(0, 0, "busy");
    @(negedge clk);
    chk(v_valid == 1'b0, "R9 ignored emit started nothing", VW'(v_valid), VW'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all act=timeout exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_mask = '0; e_valid = 1'b0; e_idx = '0;
    e_prim = 1'b0; e_wind = 1'b0; e_regs = '0; v_ready = 1'b0;
    mask_m = '0;
    for (int i = 0; i < 3; i++) exp_buf[i] = '0;
    repeat (3) @(negedge clk);
    chk(e_ready == 1'b1 && v_valid == 1'b0, "R1 in reset", VW'({e_ready, v_valid}), VW'(2));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_mask();
    t_sparse_wind_stall();
    t_zero_mask();
    t_mask_same_cycle();
    t_bad_index();
    t_busy_ignored();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule